// File: doc/BRIEF.md
# Multithreaded Gshare Branch Direction Predictor

This block predicts taken or not-taken for conditional branches in a four-thread simultaneous multithreading front end. A lookup presents a thread number and a branch address. One cycle later the block returns a prediction, read from a table of two-bit saturating counters. The table index is the word address of the branch XORed with a global history of recent outcomes. An update presents a thread number, the branch address and the resolved direction. It trains the counter that the same hash selects, and it shifts the outcome into the history register that belongs to that thread.

The parameter `SHARE_MODE` fixes at build time how threads share the two structures:
- Mode 0: one history register and one table serve every thread.
- Mode 1: each thread has its own history register, and all threads use one table.
- Mode 2: one history register is shared, and the thread number picks one of four equal slices of a single table.
- Mode 3: each thread has its own history register and its own full-size table.

After reset, a sweep loads every counter with the weakly not-taken value. During the sweep, lookups get no response and updates are dropped.

Top module: `mt_gshare_pred`

## Requirements
- R1: Reset clears every history register to zero and raises `init_busy`. `init_busy` stays high for exactly as many cycles as the table has entries, counted from the first cycle out of reset, and then stays low.
- R2: While `init_busy` is high, no `pred_valid` is produced. Updates change neither a history register nor a counter.
- R3: After the sweep, every counter holds 01, so any lookup predicts not-taken.
- R4: The hash is `pc[TABLE_AW+1:2]` XOR the selected history. Address bits 1:0 have no effect on the result.
- R5: An accepted lookup gives `pred_valid` high in the next cycle. `pred_taken` equals bit 1 of the addressed counter.
- R6: A taken update increments the counter and saturates at 11. A not-taken update decrements it and saturates at 00.
- R7: An update shifts the selected history left by one and puts 1 (taken) or 0 (not taken) in bit 0. Every other history register is left unchanged. A lookup in the same cycle uses the history as it stood before that shift.
- R8: Mode 0: every thread reads and shifts the single history, and all threads index one table of 2^TABLE_AW counters.
- R9: Mode 1: thread t reads and shifts history t, and all threads share one table of 2^TABLE_AW counters.
- R10: Mode 2: one shared history. The index is {tid, low TABLE_AW-2 bits of the hash}, so each thread owns a quarter of the table.
- R11: Mode 3: thread t owns history t and a private table of 2^TABLE_AW counters. The index is {tid, hash}.
- R12: A lookup that reads an entry in the same cycle it is written sees the old value. Two updates to one entry in consecutive cycles both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_tid | input | $clog2(THREADS) | Thread of the lookup |
| lkp_pc | input | PC_W | Branch address of the lookup |
| upd_valid | input | 1 | Training request |
| upd_tid | input | $clog2(THREADS) | Thread of the resolved branch |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| pred_valid | output | 1 | Prediction present, one cycle after lookup |
| pred_taken | output | 1 | Predicted direction |
| init_busy | output | 1 | Counter initialisation sweep in progress |

## Verification
The hardest case is a read-modify-write of one counter by two updates in consecutive cycles, together with a lookup of that entry in the cycle it is written. Taken outcomes move the history, so the hash normally changes between updates. The stimulus therefore trains with not-taken outcomes while the histories are zero, which keeps the index fixed. In mode 1 it also alternates threads whose private histories are all still zero, so back-to-back updates hit one shared entry. A long random phase then uses a small set of addresses, which makes entries alias between threads in all four modes.

// File: rtl/mtgp_pkg.sv
package mtgp_pkg;

  localparam int MODE_SHARE_ALL  = 0;
  localparam int MODE_PRIV_HIST  = 1;
  localparam int MODE_PRIV_TABLE = 2;
  localparam int MODE_PRIV_ALL   = 3;

  localparam logic [1:0] CTR_WEAK_NT = 2'b01;

  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    nxt = cur;
    if (taken && cur != 2'b11) nxt = cur + 2'd1;
    else if (!taken && cur != 2'b00) nxt = cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/mtgp_hist.sv
module mtgp_hist #(
  parameter int THREADS  = 4,
  parameter int HIST_W   = 12,
  parameter int NUM_HIST = 4,
  localparam int TID_W   = $clog2(THREADS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TID_W-1:0]  lkp_tid,
  input  logic              upd_fire,
  input  logic [TID_W-1:0]  upd_tid,
  input  logic              upd_taken,
  output logic [HIST_W-1:0] lkp_hist,
  output logic [HIST_W-1:0] upd_hist
);

  logic [HIST_W-1:0] hist_q [NUM_HIST];
  logic [NUM_HIST-1:0] shift_en;

  if (NUM_HIST == 1) begin : g_single
    assign lkp_hist = hist_q[0];
    assign upd_hist = hist_q[0];
    assign shift_en = upd_fire;
  end else begin : g_multi
    assign lkp_hist = hist_q[lkp_tid];
    assign upd_hist = hist_q[upd_tid];
    for (genvar k = 0; k < NUM_HIST; k++) begin : g_sel
      assign shift_en[k] = upd_fire && (upd_tid == TID_W'(k));
    end
  end

  for (genvar i = 0; i < NUM_HIST; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)              hist_q[i] <= '0;
      else if (shift_en[i]) hist_q[i] <= {hist_q[i][HIST_W-2:0], upd_taken};
    end

    // R7: a register that is not selected holds its value
    assert_hist_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !shift_en[i] |=> $stable(hist_q[i]));
    // R7: the outcome lands in bit 0 and older bits move up
    assert_hist_shift_R7: assert property (@(posedge clk) disable iff (rst)
      shift_en[i] |=> (hist_q[i][0] == $past(upd_taken)) &&
                      (hist_q[i][HIST_W-1:1] == $past(hist_q[i][HIST_W-2:0])));
  end

endmodule

// File: rtl/mtgp_index.sv
module mtgp_index #(
  parameter int THREADS    = 4,
  parameter int HIST_W     = 12,
  parameter int TABLE_AW   = 12,
  parameter int SHARE_MODE = 1,
  localparam int TID_W     = $clog2(THREADS),
  localparam int SLICE_AW  = TABLE_AW - TID_W,
  localparam int IDX_W     = (SHARE_MODE == mtgp_pkg::MODE_PRIV_ALL) ? TABLE_AW + TID_W : TABLE_AW
) (
  input  logic [TID_W-1:0]    tid,
  input  logic [TABLE_AW-1:0] word_pc,
  input  logic [HIST_W-1:0]   hist,
  output logic [IDX_W-1:0]    idx
);

  logic [TABLE_AW-1:0] hist_fit;
  logic [TABLE_AW-1:0] hash;

  if (HIST_W >= TABLE_AW) begin : g_trunc
    assign hist_fit = hist[TABLE_AW-1:0];
  end else begin : g_ext
    assign hist_fit = {{(TABLE_AW-HIST_W){1'b0}}, hist};
  end

  assign hash = word_pc ^ hist_fit;

  if (SHARE_MODE == mtgp_pkg::MODE_PRIV_TABLE) begin : g_slice
    assign idx = {tid, hash[SLICE_AW-1:0]};
  end else if (SHARE_MODE == mtgp_pkg::MODE_PRIV_ALL) begin : g_full
    assign idx = {tid, hash};
  end else begin : g_flat
    assign idx = hash;
  end

endmodule

// File: rtl/mtgp_pht.sv
module mtgp_pht #(
  parameter int IDX_W = 12,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] a_addr,
  output logic [1:0]       a_data,
  input  logic [IDX_W-1:0] b_addr,
  output logic [1:0]       b_data,
  input  logic             w_en,
  input  logic [IDX_W-1:0] w_addr,
  input  logic [1:0]       w_data,
  output logic             init_busy
);

  logic [1:0]       mem [DEPTH];
  logic [IDX_W-1:0] sweep_q;
  logic             busy_q;
  logic             we;
  logic [IDX_W-1:0] wa;
  logic [1:0]       wd;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b1;
      sweep_q <= '0;
    end else if (busy_q) begin
      sweep_q <= sweep_q + 1'b1;
      if (sweep_q == IDX_W'(DEPTH - 1)) busy_q <= 1'b0;
    end
  end

  always_comb begin
    we = busy_q | w_en;
    wa = busy_q ? sweep_q : w_addr;
    wd = busy_q ? mtgp_pkg::CTR_WEAK_NT : w_data;
  end

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    a_data <= mem[a_addr];
    b_data <= mem[b_addr];
  end

  assign init_busy = busy_q;

  // R1: the sweep runs once per reset
  assert_sweep_once_R1: assert property (@(posedge clk) disable iff (rst)
    !busy_q |=> !busy_q);
  // R2: no training write competes with the sweep
  assert_no_train_in_sweep_R2: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !w_en);

endmodule

// File: rtl/mt_gshare_pred.sv
module mt_gshare_pred #(
  parameter int THREADS    = 4,
  parameter int HIST_W     = 12,
  parameter int TABLE_AW   = 12,
  parameter int PC_W       = 32,
  parameter int SHARE_MODE = 1,
  localparam int TID_W     = $clog2(THREADS),
  localparam int NUM_HIST  = (SHARE_MODE == mtgp_pkg::MODE_PRIV_HIST ||
                              SHARE_MODE == mtgp_pkg::MODE_PRIV_ALL) ? THREADS : 1,
  localparam int IDX_W     = (SHARE_MODE == mtgp_pkg::MODE_PRIV_ALL) ? TABLE_AW + TID_W : TABLE_AW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lkp_valid,
  input  logic [TID_W-1:0] lkp_tid,
  input  logic [PC_W-1:0]  lkp_pc,
  input  logic             upd_valid,
  input  logic [TID_W-1:0] upd_tid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic             upd_taken,
  output logic             pred_valid,
  output logic             pred_taken,
  output logic             init_busy
);

  logic              busy;
  logic              lkp_fire, upd_fire;
  logic [HIST_W-1:0] lkp_hist, upd_hist;
  logic [IDX_W-1:0]  lkp_idx, upd_idx;
  logic [1:0]        rd_lkp, rd_upd;

  logic              s1_valid, s1_taken, s1_fwd;
  logic [IDX_W-1:0]  s1_idx;
  logic [1:0]        s1_fwd_val, s1_old, s1_new;
  logic              resp_q;

  assign lkp_fire = lkp_valid & ~busy;
  assign upd_fire = upd_valid & ~busy;

  mtgp_hist #(.THREADS(THREADS), .HIST_W(HIST_W), .NUM_HIST(NUM_HIST)) u_hist (
    .clk(clk), .rst(rst), .lkp_tid(lkp_tid), .upd_fire(upd_fire),
    .upd_tid(upd_tid), .upd_taken(upd_taken),
    .lkp_hist(lkp_hist), .upd_hist(upd_hist)
  );

  mtgp_index #(.THREADS(THREADS), .HIST_W(HIST_W), .TABLE_AW(TABLE_AW),
               .SHARE_MODE(SHARE_MODE)) u_idx_lkp (
    .tid(lkp_tid), .word_pc(lkp_pc[TABLE_AW+1:2]), .hist(lkp_hist), .idx(lkp_idx)
  );

  mtgp_index #(.THREADS(THREADS), .HIST_W(HIST_W), .TABLE_AW(TABLE_AW),
               .SHARE_MODE(SHARE_MODE)) u_idx_upd (
    .tid(upd_tid), .word_pc(upd_pc[TABLE_AW+1:2]), .hist(upd_hist), .idx(upd_idx)
  );

  mtgp_pht #(.IDX_W(IDX_W)) u_pht (
    .clk(clk), .rst(rst),
    .a_addr(lkp_idx), .a_data(rd_lkp),
    .b_addr(upd_idx), .b_data(rd_upd),
    .w_en(s1_valid), .w_addr(s1_idx), .w_data(s1_new),
    .init_busy(busy)
  );

  // training: read in the accept cycle, write one cycle later,
  // forwarding the entry written by the previous update
  always_comb begin
    s1_old = s1_fwd ? s1_fwd_val : rd_upd;
    s1_new = mtgp_pkg::ctr_step(s1_old, s1_taken);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_fwd   <= 1'b0;
      resp_q   <= 1'b0;
    end else begin
      s1_valid <= upd_fire;
      s1_fwd   <= upd_fire & s1_valid & (s1_idx == upd_idx);
      resp_q   <= lkp_fire;
    end
  end

  always_ff @(posedge clk) begin
    s1_idx     <= upd_idx;
    s1_taken   <= upd_taken;
    s1_fwd_val <= s1_new;
  end

  assign pred_valid = resp_q;
  assign pred_taken = resp_q & rd_lkp[1];
  assign init_busy  = busy;

  // R5: a response follows an accepted lookup one cycle earlier
  assert_resp_follows_lookup_R5: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> $past(lkp_valid) && !$past(busy));
  // R5: an accepted lookup always produces a response
  assert_lookup_answered_R5: assert property (@(posedge clk) disable iff (rst)
    lkp_valid && !busy |=> pred_valid);
  // R6: a taken outcome never lowers a counter, a not-taken one never raises it
  assert_train_dir_R6: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> (s1_taken ? (s1_new >= s1_old) : (s1_new <= s1_old)));
  // R2: updates refused during the sweep reach no write stage
  assert_drop_in_sweep_R2: assert property (@(posedge clk) disable iff (rst)
    busy |=> !s1_valid);

endmodule

// File: tb/mt_gshare_pred_tb.sv
`timescale 1ns/1ps
module mt_gshare_pred_tb;

  localparam int T  = 4;
  localparam int HW = 8;
  localparam int AW = 8;
  localparam int E  = 1 << AW;

  typedef struct { bit exp; string tag; } exp_t;

  logic clk = 0, rst = 1;
  logic lv = 0, uv = 0, ut = 0;
  logic [1:0]  ltid = 0, utid = 0;
  logic [31:0] lpc = 0, upc = 0;
  logic pv [4];
  logic pt [4];
  logic bz [4];

  int n_checks = 0, n_fail = 0;
  bit model_on = 0, mon_on = 0;
  int hist_m [4][4];
  int ctr_m  [4][4*E];
  bit pend_v [4];
  int pend_i [4];
  int pend_c [4];
  exp_t q [4][$];

  always #4 clk = ~clk;

  for (genvar m = 0; m < 4; m++) begin : g_mode
    mt_gshare_pred #(.THREADS(T), .HIST_W(HW), .TABLE_AW(AW), .PC_W(32), .SHARE_MODE(m)) u_dut (
      .clk(clk), .rst(rst), .lkp_valid(lv), .lkp_tid(ltid), .lkp_pc(lpc),
      .upd_valid(uv), .upd_tid(utid), .upd_pc(upc), .upd_taken(ut),
      .pred_valid(pv[m]), .pred_taken(pt[m]), .init_busy(bz[m])
    );
  end

  function automatic int hsel(int m, int tid);
    return (m == 1 || m == 3) ? tid : 0;
  endfunction

  // R4 hash, R8..R11 index placement
  function automatic int idx_of(int m, int tid, int pc, int h);
    int hash;
    hash = ((pc >> 2) & (E - 1)) ^ h;
    case (m)
      2:       return tid * (E / T) + (hash & (E / T - 1));
      3:       return tid * E + hash;
      default: return hash;
    endcase
  endfunction

  function automatic string mtag(int m);
    case (m)
      0: return "R8";
      1: return "R9";
      2: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(bit ok, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic step(bit l_v, int l_t, int l_pc, bit u_v, int u_t, int u_pc, bit u_tk, string tag);
    @(negedge clk);
    lv = l_v; ltid = 2'(l_t); lpc = l_pc;
    uv = u_v; utid = 2'(u_t); upc = u_pc; ut = u_tk;
    if (model_on) begin
      for (int m = 0; m < 4; m++) begin
        if (l_v) begin
          int li;
          string tg;
          li = idx_of(m, l_t, l_pc, hist_m[m][hsel(m, l_t)]);
          tg = (tag == "") ? mtag(m) : tag;
          q[m].push_back('{exp: (ctr_m[m][li] >= 2), tag: tg});
        end
        if (pend_v[m]) ctr_m[m][pend_i[m]] = pend_c[m];
        pend_v[m] = 0;
        if (u_v) begin
          int ui, c, hs;
          hs = hsel(m, u_t);
          ui = idx_of(m, u_t, u_pc, hist_m[m][hs]);
          c  = ctr_m[m][ui];
          if (u_tk && c < 3) c++;
          else if (!u_tk && c > 0) c--;
          pend_v[m] = 1; pend_i[m] = ui; pend_c[m] = c;
          hist_m[m][hs] = ((hist_m[m][hs] << 1) | int'(u_tk)) & ((1 << HW) - 1);
        end
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, "");
  endtask

  // monitor: pops expected predictions as responses arrive
  always @(negedge clk) begin
    if (mon_on) begin
      for (int m = 0; m < 4; m++) begin
        if (pv[m]) begin
          if (q[m].size() == 0) begin
            check(0, $sformatf("R5 mode%0d unexpected pred_valid", m), 1, 0);
          end else begin
            exp_t e;
            e = q[m].pop_front();
            check(pt[m] == e.exp, $sformatf("%s mode%0d pred_taken", e.tag, m), int'(pt[m]), int'(e.exp));
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cnt [4];
    int depth;
    bit any;
    repeat (3) @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      check(pv[m] == 0, $sformatf("R1 mode%0d pred_valid in reset", m), int'(pv[m]), 0);
      check(bz[m] == 1, $sformatf("R1 mode%0d init_busy in reset", m), int'(bz[m]), 1);
    end
    rst = 0;
    for (int m = 0; m < 4; m++) cnt[m] = 0;
    // sweep: count busy cycles, poke lookups and updates that must be ignored (R2)
    for (int cyc = 0; cyc < 5000; cyc++) begin
      any = 0;
      for (int m = 0; m < 4; m++) begin
        if (bz[m]) begin
          cnt[m]++;
          any = 1;
        end
        if (cyc > 1 && cyc < 200)
          check(pv[m] == 0, $sformatf("R2 mode%0d pred_valid during sweep", m), int'(pv[m]), 0);
      end
      if (!any) break;
      if (cyc < 200) begin
        lv = 1; ltid = 2'(cyc % 4); lpc = 32'(cyc * 4);
        uv = 1; utid = 2'(cyc % 4); upc = 32'h40; ut = 1;
      end else begin
        lv = 0; uv = 0; ut = 0;
      end
      @(negedge clk);
    end
    for (int m = 0; m < 4; m++) begin
      depth = (m == 3) ? 4 * E : E;
      check(cnt[m] == depth, $sformatf("R1 mode%0d sweep length", m), cnt[m], depth);
    end
    for (int m = 0; m < 4; m++) begin
      pend_v[m] = 0;
      for (int t = 0; t < 4; t++) hist_m[m][t] = 0;
      for (int i = 0; i < 4 * E; i++) ctr_m[m][i] = 1;
    end
    model_on = 1;
    mon_on = 1;

    // R3: fresh counters predict not-taken; R2: earlier pokes left no trace
    for (int t = 0; t < 4; t++) step(1, t, 32'h40, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 8; i++) step(1, i % 4, i * 52, 0, 0, 0, 0, "R3");
    idle(2);

    // R12: back-to-back not-taken updates at zero history hit one entry
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 32'h80, 0, "");
    step(1, 0, 32'h80, 0, 0, 0, 0, "R6");
    // R12: mode 1 threads with zero private history share the entry
    step(0, 0, 0, 1, 1, 32'h100, 1, "");
    step(0, 0, 0, 1, 2, 32'h100, 1, "");
    step(1, 3, 32'h100, 1, 3, 32'h100, 1, "R12");
    step(1, 3, 32'h100, 0, 0, 0, 0, "R12");
    step(1, 0, 32'h100, 0, 0, 0, 0, "R12");
    idle(2);

    // R4: low address bits are ignored
    for (int b = 0; b < 4; b++) step(1, 1, 32'h100 + b, 0, 0, 0, 0, "R4");
    // R6: saturate high with repeated taken outcomes on thread 2
    for (int i = 0; i < 14; i++) step(1, 2, 32'h200, 1, 2, 32'h200, 1, "R6");
    step(1, 2, 32'h200, 0, 0, 0, 0, "R6");
    // R7: other threads keep their own history after thread 2 trained
    for (int t = 0; t < 4; t++) step(1, t, 32'h204, 0, 0, 0, 0, "R7");
    // R7: alternating pattern on thread 0 with same-cycle lookups
    for (int i = 0; i < 16; i++) step(1, 0, 32'h300, 1, 0, 32'h300, i % 2, "R7");
    idle(2);

    // R8..R11: random mix over a small address set to force aliasing
    for (int i = 0; i < 4000; i++) begin
      int a, b;
      a = int'(($urandom % 24) << 2) | int'($urandom % 4);
      b = int'(($urandom % 24) << 2);
      step($urandom % 4 != 0, int'($urandom % 4), a,
           $urandom % 3 != 0, int'($urandom % 4), b, $urandom % 3 != 0, "");
    end
    idle(4);
    for (int m = 0; m < 4; m++)
      check(q[m].size() == 0, $sformatf("R5 mode%0d responses outstanding", m), q[m].size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule